// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned binary words and a carry-in with no clock. The carries do not ripple from bit to bit. Each bit first produces a generate term (both operand bits set) and a propagate term (exactly one operand bit set). A tree of carry operators then merges these terms. The tree runs in two sweeps. The first sweep reduces pairs, then groups of four, then groups of eight, and so on. The second sweep walks back down and fills in the prefixes the first sweep skipped. For a word of W bits the depth grows with log2(W), and each level holds only a few operators.

The tree works only on the operand bits. The carry-in is applied at the end: the carry into bit i+1 is the group generate of bits 0..i, OR the group propagate of bits 0..i AND the carry-in. Each sum bit is the bit's propagate XOR the carry into it. The block also brings out the generate and propagate of the whole word. A wider adder can use these two signals when it chains several copies of this block. The width is a parameter. It must be a power of two and at least 2. The default is 8.

Top module: `bk_prefix_adder`

## Requirements
- R1: `sum_o` equals the low W bits of `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit W of `a_i + b_i + cin_i`.
- R3: `grp_gen_o` is 1 exactly when `a_i + b_i` (carry-in ignored) overflows W bits.
- R4: `grp_prop_o` is 1 exactly when `a_i ^ b_i` has all W bits set.
- R5: `grp_gen_o` and `grp_prop_o` are never 1 together. No bit-level or group-level pair inside the tree is ever both 1.
- R6: When the whole word propagates, the carry-in passes straight through. `sum_o` is all ones when `cin_i` is 0. `sum_o` is all zeros and `cout_o` is 1 when `cin_i` is 1.
- R7: Bit 0 of `sum_o` equals `a_i[0] ^ b_i[0] ^ cin_i`.
- R8: With both operands and the carry-in at zero, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| grp_gen_o | output | 1 | Generate of the whole word, carry-in not included |
| grp_prop_o | output | 1 | Propagate of the whole word |

## Verification
Immediate assertions run on every evaluation. They check that generate and propagate are mutually exclusive at the bit level, at every operator in the tree and at the word outputs. They also check that the carry-in passes straight through when the whole word propagates, and that bit 0 of the sum depends only on the lowest operand bits and the carry-in. Whether the down-sweep fills every carry correctly shows only in the bench. The bench compares sum, carry-out and both group outputs against arithmetic references over all 2^17 operand and carry-in combinations.

// File: rtl/bk_adder_pkg.sv
package bk_adder_pkg;
  // Largest width the prefix tree is meant for; guards absurd instances.
  localparam int MAX_W = 1024;

  function automatic bit is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/bk_pg_gen.sv
module bk_pg_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);
  always_comb begin
    g_o = a_i & b_i;
    p_o = a_i ^ b_i;
  end

  always_comb begin
    // R5
    bit_pg_excl_chk: assert ((g_o & p_o) == '0)
      else $error("bit generate and propagate overlap");
  end
endmodule

// File: rtl/bk_carry_op.sv
module bk_carry_op (
  input  logic hi_g_i,
  input  logic hi_p_i,
  input  logic lo_g_i,
  input  logic lo_p_i,
  output logic g_o,
  output logic p_o
);
  always_comb begin
    g_o = hi_g_i | (hi_p_i & lo_g_i);
    p_o = hi_p_i & lo_p_i;
  end

  always_comb begin
    // R5
    op_excl_chk: assert (!(g_o && p_o))
      else $error("carry operator output generate and propagate overlap");
  end
endmodule

// File: rtl/bk_prefix_tree.sv
module bk_prefix_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] pre_g_o,
  output logic [W-1:0] pre_p_o
);
  localparam int LG  = $clog2(W);
  localparam int NST = 2 * LG - 1;

  for (genvar s = 0; s <= NST; s++) begin : stg
    logic [W-1:0] gv;
    logic [W-1:0] pv;
    if (s == 0) begin : base
      assign gv = g_i;
      assign pv = p_i;
    end else begin : lvl
      localparam bit UP   = (s <= LG);
      localparam int D    = UP ? s : (2 * LG - s);
      localparam int SPAN = 1 << D;
      localparam int HALF = SPAN / 2;
      for (genvar i = 0; i < W; i++) begin : col
        localparam bit MERGE = UP ? (((i + 1) % SPAN) == 0)
                                  : ((((i + 1) % SPAN) == HALF) && (i >= SPAN));
        if (MERGE) begin : op
          bk_carry_op u_op (
            .hi_g_i (stg[s-1].gv[i]),
            .hi_p_i (stg[s-1].pv[i]),
            .lo_g_i (stg[s-1].gv[i-HALF]),
            .lo_p_i (stg[s-1].pv[i-HALF]),
            .g_o    (gv[i]),
            .p_o    (pv[i])
          );
        end else begin : pass
          assign gv[i] = stg[s-1].gv[i];
          assign pv[i] = stg[s-1].pv[i];
        end
      end
    end
  end

  assign pre_g_o = stg[NST].gv;
  assign pre_p_o = stg[NST].pv;

  always_comb begin
    // R5
    prefix_excl_chk: assert ((pre_g_o & pre_p_o) == '0)
      else $error("prefix generate and propagate overlap");
  end
endmodule

// File: rtl/bk_sum_stage.sv
module bk_sum_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] pre_g_i,
  input  logic [W-1:0] pre_p_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;

  always_comb begin
    carry[0] = cin_i;
    for (int i = 0; i < W; i++) begin
      carry[i+1] = pre_g_i[i] | (pre_p_i[i] & cin_i);
    end
    sum_o  = p_i ^ carry[W-1:0];
    cout_o = carry[W];
  end
endmodule

// File: rtl/bk_prefix_adder.sv
module bk_prefix_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  import bk_adder_pkg::*;

  if (!is_pow2(W) || (W > MAX_W)) begin : bad_width
    $error("W must be a power of two between 2 and MAX_W");
  end

  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] pre_g;
  logic [W-1:0] pre_p;

  bk_pg_gen #(.W(W)) u_pg (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (bit_g),
    .p_o (bit_p)
  );

  bk_prefix_tree #(.W(W)) u_tree (
    .g_i     (bit_g),
    .p_i     (bit_p),
    .pre_g_o (pre_g),
    .pre_p_o (pre_p)
  );

  bk_sum_stage #(.W(W)) u_sum (
    .p_i     (bit_p),
    .pre_g_i (pre_g),
    .pre_p_i (pre_p),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o)
  );

  assign grp_gen_o  = pre_g[W-1];
  assign grp_prop_o = pre_p[W-1];

  always_comb begin
    // R5
    word_excl_chk: assert (!(grp_gen_o && grp_prop_o))
      else $error("word generate and propagate overlap");
    // R6
    pass_through_chk: assert (!grp_prop_o ||
                              ((sum_o == {W{~cin_i}}) && (cout_o == cin_i)))
      else $error("carry-in not passed through a fully propagating word");
    // R7
    lsb_sum_chk: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
      else $error("sum bit 0 mismatch");
  end
endmodule

// File: tb/bk_prefix_adder_test.sv
module bk_prefix_adder_test;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         c;
    logic [W-1:0] s;
    logic         co;
    logic         gg;
    logic         gp;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_r;
  logic [W-1:0] b_r;
  logic         c_r;
  logic [W-1:0] sum_w;
  logic         cout_w;
  logic         gg_w;
  logic         gp_w;

  int    checks = 0;
  int    fails  = 0;
  item_t q[$];

  always #5 clk = ~clk;

  bk_prefix_adder #(.W(W)) uut (
    .a_i        (a_r),
    .b_i        (b_r),
    .cin_i      (c_r),
    .sum_o      (sum_w),
    .cout_o     (cout_w),
    .grp_gen_o  (gg_w),
    .grp_prop_o (gp_w)
  );

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (a=%0h b=%0h cin=%0b)",
               tag, act, exp, a_r, b_r, c_r);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    item_t it;
    logic [W:0] full;
    logic [W:0] nocin;
    @(posedge clk);
    #1;
    a_r = a;
    b_r = b;
    c_r = c;
    full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    nocin = {1'b0, a} + {1'b0, b};
    it.a  = a;
    it.b  = b;
    it.c  = c;
    it.s  = full[W-1:0];
    it.co = full[W];
    it.gg = nocin[W];
    it.gp = ((a ^ b) == {W{1'b1}});
    q.push_back(it);
  endtask

  // Monitor: compares at the falling edge, away from the driving edge.
  always @(negedge clk) begin
    if (rst_n && (q.size() > 0)) begin
      item_t it;
      it = q.pop_front();
      chk("R1 sum",      {1'b0, sum_w}, {1'b0, it.s});
      chk("R2 cout",     {{W{1'b0}}, cout_w}, {{W{1'b0}}, it.co});
      chk("R3 grp_gen",  {{W{1'b0}}, gg_w}, {{W{1'b0}}, it.gg});
      chk("R4 grp_prop", {{W{1'b0}}, gp_w}, {{W{1'b0}}, it.gp});
      chk("R5 exclusive", {{W{1'b0}}, gg_w & gp_w}, '0);
      chk("R7 lsb", {{W{1'b0}}, sum_w[0]}, {{W{1'b0}}, it.a[0] ^ it.b[0] ^ it.c});
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_r = '0;
    b_r = '0;
    c_r = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: zero inputs give all-zero outputs
    chk("R8 zero", {cout_w, sum_w}, '0);
    chk("R8 zero grp", {{(W-1){1'b0}}, gg_w, gp_w}, '0);
    rst_n = 1'b1;

    // R6: full propagate, carry-in passes straight through
    drive(8'hA5, 8'h5A, 1'b0);
    drive(8'hA5, 8'h5A, 1'b1);
    drive(8'hFF, 8'h00, 1'b1);
    @(negedge clk);
    #1;
    chk("R6 pass sum", {cout_w, sum_w}, {1'b1, {W{1'b0}}});
    // Longest carry chain and mixed patterns
    drive(8'hFF, 8'h01, 1'b0);
    drive(8'h80, 8'h80, 1'b0);
    drive(8'h0F, 8'hF0, 1'b1);
    drive(8'h7F, 8'h00, 1'b1);

    // R1 R2 R3 R4: every operand and carry-in combination
    for (int k = 0; k < (1 << (2 * W + 1)); k++) begin
      drive(k[W-1:0], k[2*W-1:W], k[2*W]);
    end

    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule